// File: doc/BRIEF.md
# Machine Clock Selection Controller

This block decides whether the machine clock of a chip is taken from the main oscillator path or from a PLL. Software controls it through one 16-bit control and status word. A synchronous write port updates the word, and its current value is always present on a combinational read port. The select field and the status field are kept apart. The select field records what software asked for. The status field records which source is actually driving the machine clock.

A request to move onto the PLL does not take effect at once. While the PLL settles, the block counts a fixed number of oscillation-clock cycles, and the status keeps reporting the main clock for that whole wait. When the wait begins, the block sends a one-cycle clear to the time-base timer, which resets that timer's count and its overflow flag. Moving back to the main clock happens on the next edge and cancels any wait that is still running. Two protections guard against misuse. The multiplier code cannot be changed while the PLL is selected. A request for the PLL is refused for a short window after the main clock has been selected. The reset-cause input decides which fields a reset restores.

Top module: `mclk_sel_ctrl`

## Requirements
- R1: After a power-on (cause 00) or watchdog (cause 01) reset, the word reads 0xFC00: status=1, interval=11, select=1, multiplier=00, reserved bits 1, and `clk_src_pll_o`=0.
- R2: Bit 14 is the read-only source status. It reads 1 while the main clock is in use and 0 while the PLL is in use, and `clk_src_pll_o` is its inverse. Writes to bit 14 change nothing.
- R3: A write with bit 10 = 0 while bit 10 reads 1, outside the lock window, makes bit 10 read 0 from the next cycle. Bit 14 stays 1 for exactly 2^STAB_W cycles. It falls to 0, and `clk_src_pll_o` rises, on the 2^STAB_W-th edge after the edge that started the wait.
- R4: `tbase_clr_o` is high for exactly the one cycle after the edge that starts a stabilization wait.
- R5: The multiplier field (bits 9:8, driven on `mult_o`) takes the written value only when bit 10 reads 1 before the write. Otherwise the write leaves it unchanged.
- R6: For 2*LOCK_MCYC oscillation cycles after a write with bit 10 = 1, a write with bit 10 = 0 is ignored. With the defaults this covers the 16 edges that follow the edge of the 1-write, and the 17th edge accepts the write.
- R7: The stabilization interval field (bits 13:12) takes every written value in every mode.
- R8: Bits 15 and 11 always read 1, and bits 7:0 always read 0, whatever is written.
- R9: A write with bit 10 = 1 makes bits 10 and 14 read 1 from the next cycle. It cancels a wait in progress, so bit 14 does not fall afterwards, and it brings the source back from the PLL.
- R10: `mclk_div2_o` toggles on every oscillation-clock edge while bit 14 is 1, which gives the oscillation clock divided by two. It holds its value while bit 14 is 0.
- R11: A reset with cause 10 restores the multiplier to 00 and the interval to 11. It keeps bits 10 and 14 and the source output as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillation clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| rst_cause_i | input | 2 | Reset cause: 00 power-on, 01 watchdog, 10 other |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Current control and status word |
| clk_src_pll_o | output | 1 | 1 when the PLL drives the machine clock |
| mult_o | output | 2 | PLL multiplier code |
| tbase_clr_o | output | 1 | One-cycle clear of the time-base timer and its overflow flag |
| mclk_div2_o | output | 1 | Oscillation clock divided by two, runs only on the main clock |

## Verification
A write or a reset applied at a falling edge shows on the read word, the select output and the clear pulse one rising edge later. The source status drops exactly 2^STAB_W edges after the edge that started the wait. Each driver task therefore records the absolute cycle at which its result is due, and the monitor compares at the falling edge of that cycle and nowhere else. The check on the cycle just before the status drop and the check on the cycle of the drop together pin the wait length to the exact count. The lock window is probed by writes on its last refused edge and on its first accepted edge.

// File: rtl/mcs_pkg.sv
// Shared definitions for the machine clock selection controller.
// Assumes a 16-bit control/status word; the bit positions below are the
// fields neighbouring software decodes.
package mcs_pkg;

    typedef enum logic [1:0] {
        RC_POWER_ON = 2'b00,
        RC_WATCHDOG = 2'b01,
        RC_OTHER    = 2'b10
    } rst_cause_e;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned B_RSV_HI = 15;
    localparam int unsigned B_STAT   = 14;
    localparam int unsigned B_IVL_HI = 13;
    localparam int unsigned B_IVL_LO = 12;
    localparam int unsigned B_RSV_LO = 11;
    localparam int unsigned B_SEL    = 10;
    localparam int unsigned B_MUL_HI = 9;
    localparam int unsigned B_MUL_LO = 8;

    // A hard reset restores the select and status state; other causes keep it.
    function automatic logic is_hard_reset(input logic [1:0] cause);
        return (cause == RC_POWER_ON) || (cause == RC_WATCHDOG);
    endfunction

endpackage

// File: rtl/mcs_stab_timer.sv
// PLL stabilization timer and source status.
// Counts 2**CNT_W oscillation cycles after start_i, then drops on_main_o.
// abort_i (a return to the main clock) wins over start_i and over the count.
// Assumes start_i is raised only while on_main_o is 1.
module mcs_stab_timer #(
    parameter int unsigned CNT_W = 14
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hard_rst_i,
    input  logic start_i,
    input  logic abort_i,
    output logic waiting_o,
    output logic on_main_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             term;

    assign term = (cnt_q == {CNT_W{1'b1}});

    // Wait state, cycle count and source status.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            if (hard_rst_i) begin
                waiting_o <= 1'b0;
                cnt_q     <= '0;
                on_main_o <= 1'b1;
            end
        end else if (abort_i) begin
            waiting_o <= 1'b0;
            cnt_q     <= '0;
            on_main_o <= 1'b1;
        end else if (start_i) begin
            waiting_o <= 1'b1;
            cnt_q     <= '0;
        end else if (waiting_o) begin
            if (term) begin
                waiting_o <= 1'b0;
                cnt_q     <= '0;
                on_main_o <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // R3: the status reports the main clock for the whole wait.
    a_r3_wait_on_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
        waiting_o |-> on_main_o);

    // R3: the status drops only at the end of a wait.
    a_r3_fall_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(on_main_o) |-> $past(waiting_o));

    // R9: a return to the main clock shows in the status on the next cycle.
    a_r9_abort_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i |=> (on_main_o && !waiting_o));

endmodule

// File: rtl/mcs_lock_timer.sv
// Re-selection lock window: after arm_i, active_o stays high for LOCK_LEN
// cycles. Each new arm_i restarts the window. Every reset cause clears it.
module mcs_lock_timer #(
    parameter int unsigned LOCK_LEN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_i,
    output logic active_o
);

    localparam int unsigned LW = $clog2(LOCK_LEN + 1);

    logic [LW-1:0] left_q;

    // Remaining cycles of the lock window.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            left_q <= '0;
        end else if (arm_i) begin
            left_q <= LW'(LOCK_LEN);
        end else if (left_q != '0) begin
            left_q <= left_q - LW'(1);
        end
    end

    assign active_o = (left_q != '0);

    // R6: arming opens the window on the next cycle.
    a_r6_arm_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> active_o);

endmodule

// File: rtl/mcs_div2.sv
// Main-clock divider: toggles every oscillation cycle while run_i is high
// and holds otherwise, so it gives the oscillation clock divided by two.
module mcs_div2 (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic div_o
);

    // Toggle flop gated by the main-clock status.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_o <= 1'b0;
        end else if (run_i) begin
            div_o <= !div_o;
        end
    end

    // R10: the divider holds while the PLL is in use.
    a_r10_hold_on_pll: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && $past(rst_ni)) |=> $stable(div_o));

endmodule

// File: rtl/mclk_sel_ctrl.sv
// Machine clock selection controller (top).
// Holds the control/status word, decodes writes, and drives the source
// select, the multiplier code, the time-base timer clear and the main-clock
// divide-by-two. Assumes the first reset after power-up has a hard cause.
module mclk_sel_ctrl #(
    parameter int unsigned STAB_W    = 14,
    parameter int unsigned LOCK_MCYC = 8
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [1:0]  rst_cause_i,
    input  logic        wr_en_i,
    input  logic [15:0] wr_data_i,
    output logic [15:0] rd_data_o,
    output logic        clk_src_pll_o,
    output logic [1:0]  mult_o,
    output logic        tbase_clr_o,
    output logic        mclk_div2_o
);
    import mcs_pkg::*;

    // One machine cycle is two oscillation cycles on the main clock.
    localparam int unsigned LOCK_LEN = 2 * LOCK_MCYC;

    logic       sel_q;
    logic [1:0] ivl_q;
    logic [1:0] mul_q;
    logic       clr_q;
    logic       hard_rst;
    logic       wr_sel;
    logic       start_wait;
    logic       set_main;
    logic       lock_active;
    logic       waiting;
    logic       on_main;
    logic       wr_unused;

    assign hard_rst   = is_hard_reset(rst_cause_i);
    assign wr_sel     = wr_data_i[B_SEL];
    assign set_main   = wr_en_i && wr_sel;
    assign start_wait = wr_en_i && !wr_sel && sel_q && !lock_active;
    assign wr_unused  = ^{wr_data_i[B_RSV_HI], wr_data_i[B_STAT],
                          wr_data_i[B_RSV_LO], wr_data_i[7:0]};

    // Select bit: hard reset sets it, other causes keep it.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            if (hard_rst) begin
                sel_q <= 1'b1;
            end
        end else if (set_main) begin
            sel_q <= 1'b1;
        end else if (start_wait) begin
            sel_q <= 1'b0;
        end
    end

    // Interval field: freely writable, restored by every reset cause.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ivl_q <= 2'b11;
        end else if (wr_en_i) begin
            ivl_q <= wr_data_i[B_IVL_HI:B_IVL_LO];
        end
    end

    // Multiplier field: writable only while the main clock is selected.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mul_q <= 2'b00;
        end else if (wr_en_i && sel_q) begin
            mul_q <= wr_data_i[B_MUL_HI:B_MUL_LO];
        end
    end

    // Time-base timer clear: one cycle after the wait starts.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            clr_q <= 1'b0;
        end else begin
            clr_q <= start_wait;
        end
    end

    mcs_stab_timer #(
        .CNT_W (STAB_W)
    ) u_stab (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hard_rst_i (hard_rst),
        .start_i    (start_wait),
        .abort_i    (set_main),
        .waiting_o  (waiting),
        .on_main_o  (on_main)
    );

    mcs_lock_timer #(
        .LOCK_LEN (LOCK_LEN)
    ) u_lock (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .arm_i    (set_main),
        .active_o (lock_active)
    );

    mcs_div2 u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (on_main),
        .div_o  (mclk_div2_o)
    );

    // Read word assembly: reserved bits fixed high, low byte fixed low.
    always_comb begin
        rd_data_o                    = '0;
        rd_data_o[B_RSV_HI]          = 1'b1;
        rd_data_o[B_STAT]            = on_main;
        rd_data_o[B_IVL_HI:B_IVL_LO] = ivl_q;
        rd_data_o[B_RSV_LO]          = 1'b1;
        rd_data_o[B_SEL]             = sel_q;
        rd_data_o[B_MUL_HI:B_MUL_LO] = mul_q;
    end

    assign clk_src_pll_o = !on_main;
    assign mult_o        = mul_q;
    assign tbase_clr_o   = clr_q;

    // R2: whenever the main clock is selected, it is also the one in use.
    a_r2_sel_implies_main: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q |-> on_main);

    // R4: the clear is a single-cycle pulse.
    a_r4_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tbase_clr_o |=> !tbase_clr_o);

    // R4: a drop of the select bit comes with the clear pulse.
    a_r4_clr_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sel_q) |-> tbase_clr_o);

    // R5: the multiplier holds across writes made while the PLL is selected.
    a_r5_mult_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !sel_q) |=> $stable(mult_o));

    // R6: a refused write of 0 keeps the main clock selected.
    a_r6_lock_keeps_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_sel && sel_q && lock_active) |=> sel_q);

endmodule

// File: tb/tb_mclk_sel_ctrl.sv
// Scoreboard bench: driver tasks queue expected results with the cycle at
// which they are due; a monitor pops and compares at that cycle's falling edge.
module tb_mclk_sel_ctrl;

    localparam int STAB = 1 << 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cause;
    logic        wr_en;
    logic [15:0] wdata;
    logic [15:0] rd_data;
    logic        src_pll;
    logic [1:0]  mult;
    logic        tclr;
    logic        div2;

    typedef struct {
        int          due;
        logic [15:0] rd;
        logic        pll;
        logic        clr;
        string       req;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_it;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    always #5 clk = !clk;

    always @(posedge clk) cyc <= cyc + 1;

    mclk_sel_ctrl dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .rst_cause_i   (cause),
        .wr_en_i       (wr_en),
        .wr_data_i     (wdata),
        .rd_data_o     (rd_data),
        .clk_src_pll_o (src_pll),
        .mult_o        (mult),
        .tbase_clr_o   (tclr),
        .mclk_div2_o   (div2)
    );

    function automatic logic [15:0] mk(input logic stat, input logic [1:0] ivl,
                                       input logic sel, input logic [1:0] mul);
        return {1'b1, stat, ivl, 1'b1, sel, mul, 8'h00};
    endfunction

    task automatic expect_at(input int due, input logic [15:0] rd, input logic pll,
                             input logic clr, input string req);
        exp_t e;
        e.due = due; e.rd = rd; e.pll = pll; e.clr = clr; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic go_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: compares each queued item at its due cycle.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            mon_it = exp_q.pop_front();
            n_chk++;
            if (mon_it.due < cyc) begin
                n_fail++;
                $display("FAIL %s: item due at %0d missed, actual cycle %0d expected %0d",
                         mon_it.req, mon_it.due, cyc, mon_it.due);
            end else if (rd_data !== mon_it.rd || src_pll !== mon_it.pll
                         || tclr !== mon_it.clr) begin
                n_fail++;
                $display("FAIL %s: actual rd=%h pll=%b clr=%b expected rd=%h pll=%b clr=%b (cycle %0d)",
                         mon_it.req, rd_data, src_pll, tclr, mon_it.rd, mon_it.pll,
                         mon_it.clr, cyc);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int s;
        int a;
        logic d0;
        rst_n = 1'b0;
        cause = 2'b00;
        wr_en = 1'b0;
        wdata = '0;
        repeat (3) @(negedge clk);
        // R1 R8: power-on reset value
        expect_at(cyc + 1, 16'hFC00, 1'b0, 1'b0, "R1 R8");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 R8 R2: interval and multiplier written; reserved, status, low byte not
        a = cyc;
        expect_at(a + 1, mk(1'b1, 2'b01, 1'b1, 2'b10), 1'b0, 1'b0, "R7 R8 R2");
        expect_at(a + 2, mk(1'b1, 2'b01, 1'b1, 2'b10), 1'b0, 1'b0, "R4");
        wr(16'h16FF);

        // R6: last refused edge of the lock window
        go_to(a + 16);
        expect_at(cyc + 1, mk(1'b1, 2'b01, 1'b1, 2'b10), 1'b0, 1'b0, "R6");
        wr(16'h1200);
        // R3 R4: first accepted edge starts the wait and pulses the clear
        s = cyc;
        expect_at(s + 1, mk(1'b1, 2'b01, 1'b0, 2'b10), 1'b0, 1'b1, "R3 R4 R6");
        expect_at(s + 2, mk(1'b1, 2'b01, 1'b0, 2'b10), 1'b0, 1'b0, "R4");
        wr(16'h1200);
        @(negedge clk);
        // R5: multiplier write ignored while the PLL is selected
        expect_at(cyc + 1, mk(1'b1, 2'b01, 1'b0, 2'b10), 1'b0, 1'b0, "R5");
        wr(16'h1100);
        // R7: interval still writable during the wait
        expect_at(cyc + 1, mk(1'b1, 2'b11, 1'b0, 2'b10), 1'b0, 1'b0, "R7 R5");
        wr(16'h3100);
        // R3: exact wait length
        go_to(s + STAB - 1);
        expect_at(s + STAB, mk(1'b1, 2'b11, 1'b0, 2'b10), 1'b0, 1'b0, "R3");
        expect_at(s + STAB + 1, mk(1'b0, 2'b11, 1'b0, 2'b10), 1'b1, 1'b0, "R3 R2");
        go_to(s + STAB + 2);

        // R10: divider holds on the PLL
        d0 = div2;
        @(negedge clk);
        chk(div2 == d0, "R10", int'(div2), int'(d0));

        // R11: other-cause reset keeps select and status, clears multiplier
        expect_at(cyc + 1, mk(1'b0, 2'b11, 1'b0, 2'b00), 1'b1, 1'b0, "R11");
        rst_n = 1'b0;
        cause = 2'b10;
        @(negedge clk);
        rst_n = 1'b1;
        cause = 2'b00;
        chk(mult == 2'b00, "R11", int'(mult), 0);

        // R9 R5: return to main from the PLL; multiplier write ignored
        expect_at(cyc + 1, mk(1'b1, 2'b11, 1'b1, 2'b00), 1'b0, 1'b0, "R9 R5");
        wr(16'h3500);

        // R9: abort a wait in progress
        go_to(cyc + 20);
        a = cyc;
        expect_at(a + 1, mk(1'b1, 2'b11, 1'b0, 2'b00), 1'b0, 1'b1, "R3 R4");
        wr(16'h3000);
        @(negedge clk);
        expect_at(cyc + 1, mk(1'b1, 2'b11, 1'b1, 2'b00), 1'b0, 1'b0, "R9");
        wr(16'h3400);
        go_to(a + STAB + 4);
        expect_at(cyc + 1, mk(1'b1, 2'b11, 1'b1, 2'b00), 1'b0, 1'b0, "R9");
        @(negedge clk);

        // R10: divider toggles on the main clock
        d0 = div2;
        @(negedge clk);
        chk(div2 != d0, "R10", int'(div2), int'(!d0));
        d0 = div2;
        @(negedge clk);
        chk(div2 != d0, "R10", int'(div2), int'(!d0));

        // R5: multiplier writable on the main clock
        go_to(cyc + 20);
        expect_at(cyc + 1, mk(1'b1, 2'b11, 1'b1, 2'b11), 1'b0, 1'b0, "R5");
        wr(16'h3700);
        chk(mult == 2'b11, "R5", int'(mult), 3);

        // R1: watchdog reset value
        expect_at(cyc + 1, 16'hFC00, 1'b0, 1'b0, "R1");
        rst_n = 1'b0;
        cause = 2'b01;
        @(negedge clk);
        rst_n = 1'b1;
        cause = 2'b00;

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule